// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight condition and control flags of an 8-bit microcontroller core in one byte. The ALU loads the half carry, overflow, negative, zero and carry flags. Each of these flags has its own update enable, so an instruction changes only the flags it defines. The sign flag is never loaded directly from the ALU. Whenever the ALU updates the negative or overflow flag, the sign flag is recomputed from the new values.

The global interrupt enable is a two-state machine. It gates every interrupt request on its way to the core. Interrupt entry closes it, and it opens again on a return-from-interrupt strobe or an explicit register write. The T flag is a one-bit transfer register for the bit-copy instructions. A bit-store copies one selected bit of a register-file byte into T. A bit-load hands back that byte with the selected bit replaced by T. Software can read and write the whole byte at one fixed I/O address. Nothing is saved or restored on interrupt entry or return; only the interrupt enable reacts to those events.

The interrupt-enable machine has two states, `IE_MASKED` and `IE_OPEN`. It has these transitions:
- `open_by_write`: an I/O write with bit 7 set.
- `open_by_return`: a return strobe with no write and no entry in the same cycle.
- `close_by_entry`: interrupt entry.
- `close_by_write`: an I/O write with bit 7 clear.

Top module: `cpu_flag_reg`

## Requirements
- R1: After reset all eight flags read 0. The bit positions are fixed: bit 7 is interrupt enable (I), bit 6 is T, bit 5 half carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z) and bit 0 carry (C).
- R2: A cycle with `io_wr` high and `io_addr` equal to 6'h3F loads `io_wdata` into all eight flags, S included as written, and the new value shows on `flags_out` after that clock edge. A write to any other address changes nothing.
- R3: When `io_addr` is 6'h3F, `io_rdata` shows the current flag byte in the same cycle; for any other address it reads 0.
- R4: `alu_we` and `alu_val` are ordered {H,V,N,Z,C} from bit 4 down to bit 0. A flag whose enable is high takes its value at the clock edge, and a flag whose enable is low keeps its value. A register write in the same cycle overrides all ALU updates.
- R5: After any cycle in which the ALU updates N or V, with no register write in that cycle, S equals N xor V.
- R6: `irq_enter` clears I at the next edge. It wins over `irq_return` and over a register write in the same cycle.
- R7: `irq_return` sets I, unless interrupt entry or a register write happens in the same cycle. A register write decides I through bit 7 of the written byte.
- R8: `irq_req_out` is high only when I is 1 and at least one bit of `irq_req_in` is high.
- R9: `bst_en` copies `bit_src[bit_sel]` into T at the next edge, for any index 0 to 7. A register write in the same cycle wins.
- R10: `bld_data` equals `bit_src` with bit `bit_sel` replaced by the current T, combinationally.
- R11: Interrupt entry and return change only I. With no write, ALU enable, bit-store or interrupt event, all flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not addressed |
| alu_we | input | 5 | Per-flag update enables {H,V,N,Z,C} |
| alu_val | input | 5 | New flag values {H,V,N,Z,C} |
| irq_enter | input | 1 | Interrupt taken strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| irq_req_in | input | 8 | Individually enabled interrupt requests |
| irq_req_out | output | 1 | Request to the core, gated by I |
| bst_en | input | 1 | Bit-store strobe |
| bit_sel | input | 3 | Bit index for bit-store and bit-load |
| bit_src | input | 8 | Register-file operand |
| bld_data | output | 8 | Operand with selected bit replaced by T |
| flags_out | output | 8 | Current flag byte |

## Verification
The bench drives random ALU update patterns and compares every resulting byte against a model. A design that loads S from the ALU, or forgets to recompute it after only V changes, leaves S disagreeing with N xor V. It walks bit-store and bit-load through all eight indices with both values of T, which catches an off-by-one select or a load that disturbs neighbouring bits. It applies interrupt entry, return, and a register write in colliding cycles. A design with the wrong priority leaves I set after entry, or lets a return override a write of 0. It also checks that addresses next to 6'h3F are ignored and that requests are blocked while I is 0.

// File: rtl/flag_pkg.sv
package flag_pkg;

    typedef struct packed {
        logic ie;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic {
        IE_MASKED = 1'b0,
        IE_OPEN   = 1'b1
    } ie_state_e;

    localparam int ALU_H = 4;
    localparam int ALU_V = 3;
    localparam int ALU_N = 2;
    localparam int ALU_Z = 1;
    localparam int ALU_C = 0;
    localparam int ALU_FLAGS = 5;

endpackage

// File: rtl/flag_io_port.sv
module flag_io_port #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter logic [AW-1:0] IO_ADDR = 6'h3F
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic [DW-1:0] cur_byte,
    output logic          wr_hit,
    output logic [DW-1:0] io_rdata
);

    logic sel;

    always_comb begin
        sel      = (io_addr == IO_ADDR);
        wr_hit   = sel & io_wr;
        io_rdata = sel ? cur_byte : '0;
    end

endmodule

// File: rtl/flag_tbit_xfer.sv
module flag_tbit_xfer #(
    parameter int DW = 8,
    localparam int SELW = $clog2(DW)
) (
    input  logic [DW-1:0]   bit_src,
    input  logic [SELW-1:0] bit_sel,
    input  logic            t_cur,
    output logic            bst_bit,
    output logic [DW-1:0]   bld_data
);

    assign bst_bit = bit_src[bit_sel];

    for (genvar g = 0; g < DW; g++) begin : g_bld
        assign bld_data[g] = (bit_sel == SELW'(g)) ? t_cur : bit_src[g];
    end

endmodule

// File: rtl/flag_arith_update.sv
module flag_arith_update
    import flag_pkg::*;
(
    input  flags_t                 cur,
    input  logic [ALU_FLAGS-1:0]   alu_we,
    input  logic [ALU_FLAGS-1:0]   alu_val,
    input  logic                   wr_hit,
    input  logic [6:0]             wr_low,
    input  logic                   bst_en,
    input  logic                   bst_bit,
    output logic [6:0]             next_low
);

    flags_t nx;

    always_comb begin
        nx = cur;
        if (alu_we[ALU_H]) nx.h = alu_val[ALU_H];
        if (alu_we[ALU_V]) nx.v = alu_val[ALU_V];
        if (alu_we[ALU_N]) nx.n = alu_val[ALU_N];
        if (alu_we[ALU_Z]) nx.z = alu_val[ALU_Z];
        if (alu_we[ALU_C]) nx.c = alu_val[ALU_C];
        if (alu_we[ALU_V] | alu_we[ALU_N]) nx.s = nx.n ^ nx.v;
        if (bst_en) nx.t = bst_bit;
        if (wr_hit) next_low = wr_low;
        else        next_low = nx[6:0];
    end

endmodule

// File: rtl/flag_ie_fsm.sv
module flag_ie_fsm
    import flag_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_enter,
    input  logic               irq_return,
    input  logic               wr_hit,
    input  logic               wr_ie,
    input  logic [NUM_IRQ-1:0] irq_req_in,
    output logic               ie,
    output logic               irq_req_out
);

    ie_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IE_MASKED: begin
                if (!irq_enter && wr_hit && wr_ie)
                    state_d = IE_OPEN;           // open_by_write
                else if (!irq_enter && !wr_hit && irq_return)
                    state_d = IE_OPEN;           // open_by_return
            end
            IE_OPEN: begin
                if (irq_enter)
                    state_d = IE_MASKED;         // close_by_entry
                else if (wr_hit && !wr_ie)
                    state_d = IE_MASKED;         // close_by_write
            end
            default: state_d = IE_MASKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IE_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        ie          = (state_q == IE_OPEN);
        irq_req_out = ie & (|irq_req_in);
    end

endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
    import flag_pkg::*;
#(
    parameter int AW = 6,
    parameter logic [AW-1:0] IO_ADDR = 6'h3F,
    parameter int NUM_IRQ = 8,
    parameter int DW = 8,
    localparam int SELW = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        io_addr,
    input  logic                 io_wr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [ALU_FLAGS-1:0] alu_we,
    input  logic [ALU_FLAGS-1:0] alu_val,
    input  logic                 irq_enter,
    input  logic                 irq_return,
    input  logic [NUM_IRQ-1:0]   irq_req_in,
    output logic                 irq_req_out,
    input  logic                 bst_en,
    input  logic [SELW-1:0]      bit_sel,
    input  logic [DW-1:0]        bit_src,
    output logic [DW-1:0]        bld_data,
    output logic [7:0]           flags_out
);

    logic       wr_hit;
    logic       ie;
    logic       bst_bit;
    logic [6:0] low_q, low_d;
    flags_t     cur;

    assign cur       = flags_t'({ie, low_q});
    assign flags_out = cur;

    flag_io_port #(.AW(AW), .DW(8), .IO_ADDR(IO_ADDR)) u_io (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .cur_byte (flags_out),
        .wr_hit   (wr_hit),
        .io_rdata (io_rdata)
    );

    flag_tbit_xfer #(.DW(DW)) u_tbit (
        .bit_src  (bit_src),
        .bit_sel  (bit_sel),
        .t_cur    (cur.t),
        .bst_bit  (bst_bit),
        .bld_data (bld_data)
    );

    flag_arith_update u_arith (
        .cur      (cur),
        .alu_we   (alu_we),
        .alu_val  (alu_val),
        .wr_hit   (wr_hit),
        .wr_low   (io_wdata[6:0]),
        .bst_en   (bst_en),
        .bst_bit  (bst_bit),
        .next_low (low_d)
    );

    flag_ie_fsm #(.NUM_IRQ(NUM_IRQ)) u_ie (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_enter   (irq_enter),
        .irq_return  (irq_return),
        .wr_hit      (wr_hit),
        .wr_ie       (io_wdata[7]),
        .irq_req_in  (irq_req_in),
        .ie          (ie),
        .irq_req_out (irq_req_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

endmodule

// File: rtl/cpu_flag_reg_checker.sv
module cpu_flag_reg_checker #(
    parameter int AW = 6,
    parameter logic [AW-1:0] IO_ADDR = 6'h3F
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic [7:0]    io_wdata,
    input logic [4:0]    alu_we,
    input logic          irq_enter,
    input logic          irq_return,
    input logic          bst_en,
    input logic [2:0]    bit_sel,
    input logic [7:0]    bit_src,
    input logic          irq_req_out,
    input logic [7:0]    flags_out
);

    logic hit;
    assign hit = io_wr && (io_addr == IO_ADDR);

    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !irq_enter) |=> (flags_out == $past(io_wdata)));

    p_sign_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_we[3] || alu_we[2]) && !hit) |=> (flags_out[4] == (flags_out[3] ^ flags_out[2])));

    p_entry_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !flags_out[7]);

    p_return_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && !hit) |=> flags_out[7]);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_out[7] |-> !irq_req_out);

    p_bst_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !hit) |=> (flags_out[6] == $past(bit_src[bit_sel])));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && alu_we == 5'b0 && !bst_en && !irq_enter && !irq_return)
        |=> $stable(flags_out));

endmodule

bind cpu_flag_reg cpu_flag_reg_checker #(.AW(AW), .IO_ADDR(IO_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .alu_we      (alu_we),
    .irq_enter   (irq_enter),
    .irq_return  (irq_return),
    .bst_en      (bst_en),
    .bit_sel     (bit_sel),
    .bit_src     (bit_src),
    .irq_req_out (irq_req_out),
    .flags_out   (flags_out)
);

// File: tb/cpu_flag_reg_test.sv
module cpu_flag_reg_test;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [4:0] alu_we = '0;
    logic [4:0] alu_val = '0;
    logic       irq_enter = 1'b0;
    logic       irq_return = 1'b0;
    logic [7:0] irq_req_in = '0;
    logic       irq_req_out;
    logic       bst_en = 1'b0;
    logic [2:0] bit_sel = '0;
    logic [7:0] bit_src = '0;
    logic [7:0] bld_data;
    logic [7:0] flags_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [7:0] m = '0;

    always #10 clk = ~clk;

    cpu_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_we(alu_we),
        .alu_val(alu_val), .irq_enter(irq_enter), .irq_return(irq_return),
        .irq_req_in(irq_req_in), .irq_req_out(irq_req_out), .bst_en(bst_en),
        .bit_sel(bit_sel), .bit_src(bit_src), .bld_data(bld_data),
        .flags_out(flags_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus (called just after a falling edge)
    task automatic step(input logic [4:0] we, input logic [4:0] val,
                        input logic wr, input logic [5:0] addr, input logic [7:0] wd,
                        input logic bst, input logic [2:0] sel, input logic [7:0] src,
                        input logic ent, input logic ret, input string tag);
        logic [7:0] n;
        alu_we = we; alu_val = val; io_wr = wr; io_addr = addr; io_wdata = wd;
        bst_en = bst; bit_sel = sel; bit_src = src; irq_enter = ent; irq_return = ret;
        n = m;
        if (we[4]) n[5] = val[4];
        if (we[3]) n[3] = val[3];
        if (we[2]) n[2] = val[2];
        if (we[1]) n[1] = val[1];
        if (we[0]) n[0] = val[0];
        if (we[3] | we[2]) n[4] = n[2] ^ n[3];
        if (bst) n[6] = src[sel];
        if (ret) n[7] = 1'b1;
        if (wr && addr == 6'h3F) n = wd;
        if (ent) n[7] = 1'b0;
        sb.push_back('{exp: n, tag: tag});
        m = n;
        @(posedge clk);
        @(negedge clk);
        alu_we = '0; io_wr = 1'b0; bst_en = 1'b0; irq_enter = 1'b0; irq_return = 1'b0;
    endtask

    task automatic idle(input string tag);
        step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic wr_reg(input logic [7:0] d, input string tag);
        step(5'b0, 5'b0, 1'b1, 6'h3F, d, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare against scoreboard after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, flags_out, it.exp);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flags_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after release", flags_out, 8'h00);

        // R2 / R3 register access
        wr_reg(8'h5A, "R2 write 5A");
        io_addr = 6'h3F; #1;
        chk("R3 read addressed", io_rdata, 8'h5A);
        io_addr = 6'h3E; #1;
        chk("R3 read other addr", io_rdata, 8'h00);
        step(5'b0, 5'b0, 1'b1, 6'h3E, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R2 wrong addr ignored");
        step(5'b0, 5'b0, 1'b1, 6'h1F, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R2 wrong addr 1F ignored");
        wr_reg(8'h10, "R2 S as written");

        // R4 per-flag enables and write priority
        step(5'b00001, 5'b11111, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R4 C only");
        step(5'b10010, 5'b11111, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R4 H and Z");
        step(5'b11111, 5'b00000, 1'b1, 6'h3F, 8'h2B, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R4 write beats ALU");

        // R5 sign rule
        wr_reg(8'h00, "R5 clear");
        step(5'b01000, 5'b01000, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R5 V only");
        step(5'b00100, 5'b00100, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R5 N only");
        for (int k = 0; k < 40; k++) begin
            step(5'($urandom), 5'($urandom), 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00,
                 1'b0, 1'b0, "R5 random update");
            if (alu_we == 5'b0)
                chk("R5 S equals N xor V", {7'b0, flags_out[4]}, {7'b0, flags_out[3] ^ flags_out[2]});
        end

        // R9 / R10 bit transfer at every index
        for (int k = 0; k < 8; k++) begin
            for (int tv = 0; tv < 2; tv++) begin
                logic [7:0] src;
                src = (tv == 1) ? (8'h01 << k) : ~(8'h01 << k);
                step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b1, 3'(k), src, 1'b0, 1'b0, "R9 bit store");
                bit_sel = 3'(k); bit_src = (tv == 1) ? 8'h00 : 8'hFF; #1;
                chk("R10 bit load", bld_data,
                    (tv == 1) ? (8'h01 << k) : ~(8'h01 << k));
            end
        end
        step(5'b0, 5'b0, 1'b1, 6'h3F, 8'h00, 1'b1, 3'd0, 8'hFF, 1'b0, 1'b0, "R9 write beats store");

        // R6 / R7 / R8 / R11 interrupt enable sequence
        wr_reg(8'h83, "R7 write sets I");
        irq_req_in = 8'h04; #1;
        chk("R8 request passes", {7'b0, irq_req_out}, 8'h01);
        step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R6 entry clears I R11");
        #1;
        chk("R8 request blocked", {7'b0, irq_req_out}, 8'h00);
        idle("R11 hold");
        step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R7 return sets I R11");
        irq_req_in = 8'h00; #1;
        chk("R8 no request", {7'b0, irq_req_out}, 8'h00);
        step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R6 entry beats return");
        step(5'b0, 5'b0, 1'b1, 6'h3F, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R6 entry beats write");
        step(5'b0, 5'b0, 1'b1, 6'h3F, 8'h11, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R7 write 0 beats return");
        step(5'b0, 5'b0, 1'b0, 6'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R7 return again");
        idle("R11 idle");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule